// File: doc/BRIEF.md
# Gray-Coded Multi-Bit Clock-Domain Crossing Synchronizer

This block moves a binary value that behaves like a counter (it only ever steps up or down by one) from a source clock domain into an unrelated destination clock domain without ever presenting a value that was not sent. On the source side the binary word is turned into its Gray form, g = b ^ (b >> 1), and held in a register clocked by the source clock. That registered word is the only thing that crosses. Because successive source values differ by one, only one Gray bit toggles per update, so a destination flop that samples mid-change resolves to either the old or the new code.

In the destination domain a chain of flip-flops, whose depth is a parameter between 2 and 10 (default 4), resynchronizes the Gray word. A prefix XOR running from the top bit down turns it back into binary. By default that binary result drives the output directly from the last chain stage; a parameter adds one more destination register for a registered output at the cost of one extra cycle. The bus width is a parameter from 2 to 32 (default 2). Each domain has its own synchronous, active-high reset that clears its registers to zero. A simulation-only check, enabled by a parameter, flags any source update that is not a step of plus or minus one.

Top module: `gray_cdc_sync`

## Requirements
- R1: One destination clock edge after `dst_rst` is sampled high, `dst_bin` is zero, in both output modes.
- R2: With `src_bin` held, `dst_bin` equals it no later than SYNC_STAGES+1 destination edges after the source edge that captured it (SYNC_STAGES+2 in registered mode).
- R3: Across a run of ±1 source steps, `dst_bin` passes through the sent values strictly in the order they were sent, never skipping one and never showing a value that was not sent.
- R4: After the source stops changing, `dst_bin` settles on the last source value.
- R5: Stepping from all ones to zero, and from zero to all ones, counts as a single step and is carried across like any other step.
- R6: A change of direction (counting up, then down, then up again) is carried across in order with no extra or missing values.
- R7: With OUT_MODE set to the registered mode, `dst_bin` equals the combinational-mode output one destination cycle later.
- R8: Per destination cycle the resynchronized Gray word changes in at most one bit, and `dst_bin` changes by 0, +1 or −1 modulo 2^WIDTH.
- R9: With CHECK_STEP = 1, any source update that is not +1 or −1 modulo 2^WIDTH is flagged in simulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst | input | 1 | Source-domain synchronous reset, active high |
| src_bin | input | WIDTH | Binary value to carry across; must step by ±1 |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst | input | 1 | Destination-domain synchronous reset, active high |
| dst_bin | output | WIDTH | Binary value rebuilt in the destination domain |

## Verification
The assertions take for granted that `src_bin` only ever moves by one modulo 2^WIDTH per source cycle, and that the destination clock samples every source value at least twice. Without these two conditions the single-bit Gray change and the ±1 output step cannot be guaranteed. The stimulus keeps to both conditions. It drives a source clock more than three times slower than the destination clock. Every new value is one step away from the previous one, including the wrap steps between all ones and zero. Both domains are held in reset together with the source at zero, so the first comparisons after reset start from a known word.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int MAX_W = 32;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REGD = 1'b1
    } out_mode_e;

    function automatic logic [MAX_W-1:0] bin_to_gray(input logic [MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [MAX_W-1:0] gray_to_bin(input logic [MAX_W-1:0] g);
        logic [MAX_W-1:0] b;
        b[MAX_W-1] = g[MAX_W-1];
        for (int i = MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/gcs_src_encode.sv
module gcs_src_encode #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bin_in,
    output logic [WIDTH-1:0] gray_q
);
    logic [WIDTH-1:0] gray_d;

    always_comb begin
        gray_d = WIDTH'(gcs_pkg::bin_to_gray(gcs_pkg::MAX_W'(bin_in)));
    end

    always_ff @(posedge clk) begin
        if (rst) gray_q <= '0;
        else     gray_q <= gray_d;
    end
endmodule

// File: rtl/gcs_sync_chain.sv
module gcs_sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gcs_dst_decode.sv
module gcs_dst_decode #(
    parameter int                WIDTH    = 2,
    parameter gcs_pkg::out_mode_e OUT_MODE = gcs_pkg::OUT_COMB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_out
);
    logic [WIDTH-1:0] bin_d;

    always_comb begin
        bin_d = WIDTH'(gcs_pkg::gray_to_bin(gcs_pkg::MAX_W'(gray_in)));
    end

    if (OUT_MODE == gcs_pkg::OUT_REGD) begin : g_reg
        logic [WIDTH-1:0] bin_q;
        always_ff @(posedge clk) begin
            if (rst) bin_q <= '0;
            else     bin_q <= bin_d;
        end
        assign bin_out = bin_q;
    end else begin : g_comb
        assign bin_out = bin_d;
    end
endmodule

// File: rtl/gray_cdc_sync.sv
module gray_cdc_sync #(
    parameter int                 WIDTH       = 2,
    parameter int                 SYNC_STAGES = 4,
    parameter gcs_pkg::out_mode_e OUT_MODE    = gcs_pkg::OUT_COMB,
    parameter bit                 CHECK_STEP  = 1'b1
) (
    input  logic             src_clk,
    input  logic             src_rst,
    input  logic [WIDTH-1:0] src_bin,
    input  logic             dst_clk,
    input  logic             dst_rst,
    output logic [WIDTH-1:0] dst_bin
);
    logic [WIDTH-1:0] src_gray_q;
    logic [WIDTH-1:0] sync_last;

    gcs_src_encode #(.WIDTH(WIDTH)) enc_i (
        .clk    (src_clk),
        .rst    (src_rst),
        .bin_in (src_bin),
        .gray_q (src_gray_q)
    );

    gcs_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) chain_i (
        .clk  (dst_clk),
        .rst  (dst_rst),
        .din  (src_gray_q),
        .dout (sync_last)
    );

    gcs_dst_decode #(.WIDTH(WIDTH), .OUT_MODE(OUT_MODE)) dec_i (
        .clk     (dst_clk),
        .rst     (dst_rst),
        .gray_in (sync_last),
        .bin_out (dst_bin)
    );
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker #(
    parameter int WIDTH      = 2,
    parameter bit CHECK_STEP = 1'b1
) (
    input logic             src_clk,
    input logic             src_rst,
    input logic [WIDTH-1:0] src_bin,
    input logic             dst_clk,
    input logic             dst_rst,
    input logic [WIDTH-1:0] sync_last,
    input logic [WIDTH-1:0] dst_bin
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1: reset clears the output one destination edge later
    assert_out_reset_R1: assert property (@(posedge dst_clk)
        dst_rst |=> (dst_bin == '0));

    // R8: resynchronized Gray word moves at most one bit per cycle
    assert_gray_one_bit_R8: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $countones(sync_last ^ $past(sync_last)) <= 1);

    // R8: rebuilt binary output moves by 0 or +/-1
    assert_out_step_R8: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (dst_bin == $past(dst_bin)) ||
        (dst_bin == $past(dst_bin) + ONE) ||
        (dst_bin == $past(dst_bin) - ONE));

    if (CHECK_STEP) begin : g_step_chk
        // R9: source may only step by +/-1 modulo 2^WIDTH
        assert_src_step_R9: assert property (@(posedge src_clk) disable iff (src_rst)
            (src_bin == $past(src_bin)) ||
            (src_bin == $past(src_bin) + ONE) ||
            (src_bin == $past(src_bin) - ONE))
            else $error("R9: source stepped from %0d to %0d", $past(src_bin), src_bin);
    end
endmodule

bind gray_cdc_sync gcs_checker #(.WIDTH(WIDTH), .CHECK_STEP(CHECK_STEP)) chk_i (
    .src_clk   (src_clk),
    .src_rst   (src_rst),
    .src_bin   (src_bin),
    .dst_clk   (dst_clk),
    .dst_rst   (dst_rst),
    .sync_last (sync_last),
    .dst_bin   (dst_bin)
);

// File: tb/gray_cdc_sync_tb_top.sv
`timescale 1ns/100ps
module gray_cdc_sync_tb_top;
    localparam int W      = 4;
    localparam int STAGES = 4;
    localparam int MASK   = (1 << W) - 1;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst = 1'b1;
    logic         dst_rst = 1'b1;
    logic [W-1:0] src_bin = '0;
    logic [W-1:0] dst_bin;
    logic [W-1:0] dst_bin_r;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // sent-value log for the ordering monitor
    int  sent_log [1024];
    int  sent_cnt = 1;
    int  mon_idx  = 0;
    bit  mon_on   = 1'b0;
    int  err_r3   = 0;
    int  err_r7   = 0;
    int  err_r8   = 0;
    int  bad_steps = 0;
    int  prev_comb = 0;
    bit  prev_ok  = 1'b0;

    always #10   dst_clk = ~dst_clk;   // 50 MHz destination clock
    always #33.5 src_clk = ~src_clk;   // slower source clock

    gray_cdc_sync #(.WIDTH(W), .SYNC_STAGES(STAGES),
                    .OUT_MODE(gcs_pkg::OUT_COMB), .CHECK_STEP(1'b1)) dut_i (
        .src_clk(src_clk), .src_rst(src_rst), .src_bin(src_bin),
        .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_bin(dst_bin));

    gray_cdc_sync #(.WIDTH(W), .SYNC_STAGES(STAGES),
                    .OUT_MODE(gcs_pkg::OUT_REGD), .CHECK_STEP(1'b1)) dut_reg_i (
        .src_clk(src_clk), .src_rst(src_rst), .src_bin(src_bin),
        .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_bin(dst_bin_r));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // destination-side monitor, sampled away from the active edge
    always @(negedge dst_clk) begin
        if (mon_on) begin
            if (int'(dst_bin) != sent_log[mon_idx]) begin
                if (mon_idx + 1 < sent_cnt && int'(dst_bin) == sent_log[mon_idx+1])
                    mon_idx++;
                else begin
                    err_r3++;
                    $display("R3 ordering violation: saw %0d while at %0d", dst_bin, sent_log[mon_idx]);
                end
            end
            if (prev_ok) begin
                if (int'(dst_bin_r) != prev_comb) err_r7++;
                if (!((int'(dst_bin) == prev_comb) ||
                      (int'(dst_bin) == ((prev_comb + 1) & MASK)) ||
                      (int'(dst_bin) == ((prev_comb - 1) & MASK)))) err_r8++;
            end
            prev_comb = int'(dst_bin);
            prev_ok   = 1'b1;
        end
    end

    task automatic drive(input int v);
        int cur;
        cur = int'(src_bin);
        if (!(v == cur || v == ((cur + 1) & MASK) || v == ((cur - 1) & MASK))) bad_steps++;
        @(negedge src_clk);
        src_bin = W'(v);
        if (v != cur) begin
            sent_log[sent_cnt] = v;
            sent_cnt++;
        end
    endtask

    task automatic step_up(input int n);
        for (int i = 0; i < n; i++) drive((int'(src_bin) + 1) & MASK);
    endtask

    task automatic step_down(input int n);
        for (int i = 0; i < n; i++) drive((int'(src_bin) - 1) & MASK);
    endtask

    task automatic settle_check(input string req);
        repeat (3) @(posedge src_clk);
        repeat (STAGES + 4) @(posedge dst_clk);
        @(negedge dst_clk);
        check(dst_bin == src_bin, req, int'(dst_bin), int'(src_bin));
        check(dst_bin_r == src_bin, req, int'(dst_bin_r), int'(src_bin));
        check(err_r3 == 0, "R3", err_r3, 0);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge src_clk);
        @(negedge dst_clk);
        check(dst_bin == '0, "R1 comb", int'(dst_bin), 0);
        check(dst_bin_r == '0, "R1 regd", int'(dst_bin_r), 0);
        @(negedge src_clk);
        src_rst = 1'b0;
        @(negedge dst_clk);
        dst_rst = 1'b0;
        mon_on  = 1'b1;
    endtask

    task automatic t_hold();
        step_up(3);
        @(posedge src_clk);
        repeat (STAGES + 2) @(posedge dst_clk);
        @(negedge dst_clk);
        check(int'(dst_bin) == 3, "R2 comb", int'(dst_bin), 3);
        check(int'(dst_bin_r) == 3, "R2 regd", int'(dst_bin_r), 3);
    endtask

    task automatic t_count_up();
        step_up(20);
        settle_check("R4");
    endtask

    task automatic t_wrap_up();
        int up_n;
        up_n = (MASK - int'(src_bin)) + 3;
        step_up(up_n);
        settle_check("R5 up-wrap");
        check(int'(src_bin) == 2, "R5 up-wrap value", int'(src_bin), 2);
    endtask

    task automatic t_wrap_down();
        step_down(5);
        settle_check("R5 down-wrap");
        check(int'(dst_bin) == MASK - 2, "R5 down-wrap value", int'(dst_bin), MASK - 2);
    endtask

    task automatic t_reverse();
        step_up(4);
        step_down(7);
        step_up(2);
        step_down(1);
        settle_check("R6");
    endtask

    task automatic t_final();
        check(err_r7 == 0, "R7", err_r7, 0);
        check(err_r8 == 0, "R8", err_r8, 0);
        check(bad_steps == 0, "R9", bad_steps, 0);
        check(mon_idx == sent_cnt - 1, "R3 all values seen", mon_idx, sent_cnt - 1);
    endtask

    initial begin
        sent_log[0] = 0;
        t_reset();
        t_hold();
        t_count_up();
        t_wrap_up();
        t_wrap_down();
        t_reverse();
        t_final();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule